// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of an 8-bit parallel DAC port and turns abstract requests into bus cycles that meet the converter's timing rules. A request is either a channel/code pair for one of three output channels, or a command to put the converter into its low-power state. Requests arrive over a valid/ready handshake. The sequencer drives a 2-bit address, an 8-bit data bus and an active-low write strobe. The setup, strobe-low and hold phases are each set as a whole number of clock cycles through parameters.

Address and data change together in the cycle after a request is accepted. The strobe only falls once both the address-setup and the data-setup windows have elapsed. It stays low for a fixed width and then rises, and address and data are then held for a hold window. A shutdown is sent as a write to address 3. It is followed by a wait that covers the converter's power-down time. The sequencer remembers that the target is asleep. The next channel write then adds a recovery wait before new work is accepted.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `dac_wr_no` is 1, `dac_addr_o` is 0, `dac_data_o` is 0, `req_ready_o` is 1 and `busy_o` is 0.
- R2: In the cycle after a request is accepted (`req_valid_i` and `req_ready_o` high at a clock edge), `dac_data_o` equals `req_code_i` and `dac_wr_no` is still 1. `dac_addr_o` equals `req_chan_i` (0, 1 or 2) for a channel write. It equals 3 when `req_shdn_i` is 1 or `req_chan_i` is 3, and both of these count as a shutdown request.
- R3: The strobe falls exactly SU = max(ADDR_SETUP, DATA_SETUP) clock cycles after the accepting edge. Address and data do not change in between.
- R4: The strobe stays low for exactly STROBE_CYC cycles. Address and data do not change while it is low.
- R5: After the strobe rises, address and data stay unchanged for at least HOLD_CYC cycles.
- R6: `req_ready_o` is high only when the sequencer is idle, and `busy_o` is its complement. A request held valid while the sequencer is busy is not accepted until ready returns. Each accepted request produces exactly one strobe pulse.
- R7: For a channel write while the target is awake, `req_ready_o` returns SU+STROBE_CYC+HOLD_CYC cycles after the accepting edge.
- R8: For a shutdown request, `req_ready_o` returns SHDN_WAIT cycles later than in R7. This also applies when the target is already asleep.
- R9: The first channel write after a shutdown adds WAKE_WAIT cycles to the R7 latency. Later channel writes add nothing.
- R10: Reset marks the target as awake, so the first channel write after reset has no recovery wait, even if a shutdown was the last request before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_shdn_i | input | 1 | Request is a shutdown command |
| req_chan_i | input | 2 | Target channel (0..2; 3 also means shutdown) |
| req_code_i | input | 8 | Code to write |
| busy_o | output | 1 | Bus cycle or wait in progress |
| dac_addr_o | output | 2 | DAC address bus |
| dac_data_o | output | 8 | DAC data bus |
| dac_wr_no | output | 1 | DAC write strobe, active low |

## Verification
The assertions check the bus timing on every cycle:
- the accepted request appears on the bus one cycle later;
- the strobe falls exactly SU cycles after acceptance;
- the low pulse width is exact;
- address and data stay still while the strobe is low;
- the hold window after the strobe rises is respected;
- the sequencer is never ready while it is busy.

The waits that depend on history can only be shown by the bench scenarios. These are the shutdown delay, the recovery delay on the first write after a shutdown, the absence of that delay on later writes and after reset, and the stalling of a request held valid while busy. The bench sweeps every code on every channel and measures setup, width, hold and accept-to-ready latency against arithmetic expectations.

// File: rtl/dac_wr_pkg.sv
`timescale 1ns/1ps
package dac_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_WAIT
  } seq_state_e;

  localparam logic [1:0] SHDN_ADDR = 2'd3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_wr_timer.sv
`timescale 1ns/1ps
module dac_wr_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dac_wr_ctrl.sv
`timescale 1ns/1ps
module dac_wr_ctrl
  import dac_wr_pkg::*;
#(
  parameter int unsigned ADDR_SETUP = 1,
  parameter int unsigned DATA_SETUP = 3,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned SHDN_WAIT  = 2000,
  parameter int unsigned WAKE_WAIT  = 1300,
  parameter int unsigned CW         = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          req_is_shdn_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          accept_o,
  output logic          strobe_d_o,
  output logic          idle_o
);

  localparam int unsigned SU = max2(ADDR_SETUP, DATA_SETUP);
  localparam logic [CW-1:0] SU_LD   = CW'(SU - 1);
  localparam logic [CW-1:0] ST_LD   = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HD_LD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SHDN_LD = CW'(SHDN_WAIT - 1);
  localparam logic [CW-1:0] WAKE_LD = CW'(WAKE_WAIT - 1);

  seq_state_e state_q, state_d;
  logic shdn_q, wake_q, asleep_q;

  assign idle_o   = (state_q == ST_IDLE);
  assign accept_o = idle_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (accept_o) begin
        state_d = ST_SETUP; tmr_load_o = 1'b1; tmr_val_o = SU_LD;
      end
      ST_SETUP: if (tmr_done_i) begin
        state_d = ST_STROBE; tmr_load_o = 1'b1; tmr_val_o = ST_LD;
      end
      ST_STROBE: if (tmr_done_i) begin
        state_d = ST_HOLD; tmr_load_o = 1'b1; tmr_val_o = HD_LD;
      end
      ST_HOLD: if (tmr_done_i) begin
        if (shdn_q) begin
          state_d = ST_WAIT; tmr_load_o = 1'b1; tmr_val_o = SHDN_LD;
        end else if (wake_q) begin
          state_d = ST_WAIT; tmr_load_o = 1'b1; tmr_val_o = WAKE_LD;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WAIT: if (tmr_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign strobe_d_o = (state_d == ST_STROBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      shdn_q   <= 1'b0;
      wake_q   <= 1'b0;
      asleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) begin
        shdn_q   <= req_is_shdn_i;
        // recovery wait only when leaving the low-power state
        wake_q   <= !req_is_shdn_i && asleep_q;
        asleep_q <= req_is_shdn_i;
      end
    end
  end

endmodule

// File: rtl/dac_wr_bus.sv
`timescale 1ns/1ps
module dac_wr_bus #(
  parameter int unsigned AW = 2,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          strobe_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          wr_no
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      data_o <= '0;
      wr_no  <= 1'b1;
    end else begin
      if (load_i) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
      wr_no <= !strobe_i;
    end
  end

endmodule

// File: rtl/dac_wr_seq.sv
`timescale 1ns/1ps
module dac_wr_seq
  import dac_wr_pkg::*;
#(
  parameter int unsigned ADDR_SETUP = 1,
  parameter int unsigned DATA_SETUP = 3,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1,
  parameter int unsigned SHDN_WAIT  = 2000,
  parameter int unsigned WAKE_WAIT  = 1300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic       req_shdn_i,
  input  logic [1:0] req_chan_i,
  input  logic [7:0] req_code_i,
  output logic       busy_o,
  output logic [1:0] dac_addr_o,
  output logic [7:0] dac_data_o,
  output logic       dac_wr_no
);

  localparam int unsigned SU   = max2(ADDR_SETUP, DATA_SETUP);
  localparam int unsigned MAXV = max2(max2(max2(SU, STROBE_CYC), HOLD_CYC),
                                      max2(SHDN_WAIT, WAKE_WAIT));
  localparam int unsigned CW   = $clog2(MAXV + 1);

  logic          is_shdn, accept, idle, strobe_d, tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic [1:0]    tgt_addr;

  assign is_shdn  = req_shdn_i || (req_chan_i == SHDN_ADDR);
  assign tgt_addr = is_shdn ? SHDN_ADDR : req_chan_i;

  dac_wr_ctrl #(
    .ADDR_SETUP(ADDR_SETUP), .DATA_SETUP(DATA_SETUP), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .SHDN_WAIT(SHDN_WAIT), .WAKE_WAIT(WAKE_WAIT), .CW(CW)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i,
    .req_is_shdn_i(is_shdn),
    .tmr_done_i(tmr_done),
    .tmr_load_o(tmr_load),
    .tmr_val_o(tmr_val),
    .accept_o(accept),
    .strobe_d_o(strobe_d),
    .idle_o(idle)
  );

  dac_wr_timer #(.CW(CW)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load),
    .load_val_i(tmr_val),
    .done_o(tmr_done)
  );

  dac_wr_bus #(.AW(2), .DW(8)) u_bus (
    .clk_i, .rst_ni,
    .load_i(accept),
    .addr_i(tgt_addr),
    .data_i(req_code_i),
    .strobe_i(strobe_d),
    .addr_o(dac_addr_o),
    .data_o(dac_data_o),
    .wr_no(dac_wr_no)
  );

  assign req_ready_o = idle;
  assign busy_o      = !idle;

endmodule

// File: rtl/dac_wr_seq_chk.sv
`timescale 1ns/1ps
module dac_wr_seq_chk #(
  parameter int unsigned ADDR_SETUP = 1,
  parameter int unsigned DATA_SETUP = 3,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned HOLD_CYC   = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       req_shdn_i,
  input logic [1:0] req_chan_i,
  input logic [7:0] req_code_i,
  input logic       busy_o,
  input logic [1:0] dac_addr_o,
  input logic [7:0] dac_data_o,
  input logic       dac_wr_no
);

  localparam int unsigned SU  = (ADDR_SETUP > DATA_SETUP) ? ADDR_SETUP : DATA_SETUP;
  localparam int unsigned CCW = $clog2(SU + STROBE_CYC + HOLD_CYC + 4) + 1;
  localparam logic [CCW-1:0] CMAX = '1;

  logic [CCW-1:0] acc_cnt, low_cnt, hi_cnt;
  logic acc;
  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_cnt <= CMAX;
      low_cnt <= '0;
      hi_cnt  <= CMAX;
    end else begin
      acc_cnt <= acc ? '0 : ((acc_cnt != CMAX) ? acc_cnt + 1'b1 : acc_cnt);
      low_cnt <= !dac_wr_no ? ((low_cnt != CMAX) ? low_cnt + 1'b1 : low_cnt) : '0;
      hi_cnt  <= !dac_wr_no ? '0 : ((hi_cnt != CMAX) ? hi_cnt + 1'b1 : hi_cnt);
    end
  end

  AST_ACCEPT_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (dac_data_o == $past(req_code_i)) && dac_wr_no &&
            (dac_addr_o == (($past(req_shdn_i) || $past(req_chan_i) == 2'd3) ? 2'd3 : $past(req_chan_i)))); // R2
  AST_SETUP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_wr_no) |-> (acc_cnt == CCW'(SU))); // R3
  AST_STROBE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_wr_no) |-> (low_cnt == CCW'(STROBE_CYC))); // R4
  AST_STABLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dac_wr_no && !$past(dac_wr_no)) |-> ($stable(dac_addr_o) && $stable(dac_data_o))); // R4
  AST_HOLD_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |-> (hi_cnt >= CCW'(HOLD_CYC))); // R5
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !req_ready_o); // R6
  AST_STROBE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_wr_no |-> busy_o); // R6

endmodule

bind dac_wr_seq dac_wr_seq_chk #(
  .ADDR_SETUP(ADDR_SETUP), .DATA_SETUP(DATA_SETUP),
  .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_shdn_i(req_shdn_i), .req_chan_i(req_chan_i), .req_code_i(req_code_i),
  .busy_o(busy_o), .dac_addr_o(dac_addr_o), .dac_data_o(dac_data_o), .dac_wr_no(dac_wr_no)
);

// File: tb/sim_dac_wr_seq.sv
`timescale 1ns/1ps
module sim_dac_wr_seq;

  localparam int ASU = 2, DSU = 4, STC = 3, HDC = 2, SDW = 9, WKW = 6;
  localparam int SU = (ASU > DSU) ? ASU : DSU;
  localparam int BASE = SU + STC + HDC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_shdn = 1'b0;
  logic [1:0] req_chan = '0;
  logic [7:0] req_code = '0;
  logic ready, busy, wr_n;
  logic [1:0] addr;
  logic [7:0] data;

  int n_chk = 0, n_err = 0, cyc = 0;
  int fall_k = 0, rise_k = -1000, width = 0, strobes = 0;
  logic [1:0] st_addr = '0, p_addr = '0;
  logic [7:0] st_data = '0, p_data = '0;
  logic p_wr_n = 1'b1;
  bit model_asleep = 0;

  always #5 clk = ~clk;

  dac_wr_seq #(
    .ADDR_SETUP(ASU), .DATA_SETUP(DSU), .STROBE_CYC(STC),
    .HOLD_CYC(HDC), .SHDN_WAIT(SDW), .WAKE_WAIT(WKW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_shdn_i(req_shdn), .req_chan_i(req_chan), .req_code_i(req_code),
    .busy_o(busy), .dac_addr_o(addr), .dac_data_o(data), .dac_wr_no(wr_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // bus monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      p_addr = addr; p_data = data; p_wr_n = wr_n; rise_k = -1000;
    end else begin
      cyc++;
      if (addr != p_addr || data != p_data) begin
        check(p_wr_n && wr_n, "R4 bus changed while strobe low", int'(wr_n), 1);
        check(cyc - rise_k > HDC, "R5 hold after strobe rise", cyc - rise_k, HDC + 1);
      end
      if (p_wr_n && !wr_n) begin
        fall_k = cyc; st_addr = addr; st_data = data; strobes++;
      end
      if (!p_wr_n && wr_n) begin
        rise_k = cyc; width = cyc - fall_k;
      end
      p_addr = addr; p_data = data; p_wr_n = wr_n;
    end
  end

  task automatic issue(input bit shdn, input logic [1:0] chan, input logic [7:0] code,
                       input bit stall, input string ltag);
    bit tgt_sh;
    int exp_addr, exp_l, acc_k, s0, n, bad;
    tgt_sh   = shdn || (chan == 2'd3);
    exp_addr = tgt_sh ? 3 : int'(chan);
    exp_l    = BASE + (tgt_sh ? SDW : (model_asleep ? WKW : 0));
    req_valid = 1'b1; req_shdn = shdn; req_chan = chan; req_code = code;
    while (!ready) @(negedge clk);
    #1;
    @(posedge clk);
    #1;
    acc_k = cyc + 1;
    s0 = strobes;
    model_asleep = tgt_sh;
    if (stall) begin
      req_shdn = 1'b0; req_chan = 2'd2; req_code = ~code;
    end else begin
      req_valid = 1'b0;
    end
    n = 0; bad = 0;
    do begin
      @(negedge clk);
      n++;
      if (busy == ready) bad++;
    end while (!ready);
    #1;
    check(int'(st_addr) == exp_addr, "R2 strobed address", int'(st_addr), exp_addr);
    check(st_data == code, "R2 strobed data", int'(st_data), int'(code));
    check(fall_k - acc_k == SU, "R3 accept to strobe fall", fall_k - acc_k, SU);
    check(width == STC, "R4 strobe width", width, STC);
    check(strobes - s0 == 1, "R6 one strobe per request", strobes - s0, 1);
    check(bad == 0, "R6 busy complements ready", bad, 0);
    check(n == exp_l + 1, ltag, n - 1, exp_l);
  endtask

  initial begin
    #1_500_000;
    check(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wr_n && addr == 0 && data == 0, "R1 bus in reset", {wr_n, addr, data}, 11'h400);
    check(ready && !busy, "R1 handshake in reset", {ready, busy}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(wr_n && addr == 0 && data == 0 && ready && !busy, "R1 idle after reset",
          {wr_n, ready, busy}, 6);

    // every code on every channel, target awake
    for (int c = 0; c < 3; c++)
      for (int v = 0; v < 256; v++)
        issue(1'b0, 2'(c), 8'(v), 1'b0, "R7 awake write latency");

    issue(1'b1, 2'd0, 8'h5a, 1'b0, "R8 shutdown latency");
    issue(1'b1, 2'd1, 8'h00, 1'b0, "R8 repeated shutdown latency");
    issue(1'b0, 2'd1, 8'h80, 1'b0, "R9 wake write latency");
    issue(1'b0, 2'd2, 8'h7f, 1'b0, "R9 no wait after wake");
    issue(1'b0, 2'd3, 8'hc3, 1'b0, "R8 channel 3 acts as shutdown");
    issue(1'b0, 2'd0, 8'hff, 1'b0, "R9 wake after channel-3 shutdown");

    // request held valid while busy must stall
    issue(1'b0, 2'd0, 8'h11, 1'b1, "R6 stalled request latency");
    issue(1'b0, 2'd2, 8'hee, 1'b0, "R6 stalled request completes");
    issue(1'b1, 2'd0, 8'h22, 1'b1, "R6 stall behind shutdown");
    issue(1'b0, 2'd2, 8'hdd, 1'b0, "R9 stalled write gets wake wait");

    // reset clears the sleep state
    issue(1'b1, 2'd0, 8'h33, 1'b0, "R8 shutdown before reset");
    @(negedge clk);
    rst_n = 1'b0;
    model_asleep = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(ready && wr_n && addr == 0, "R1 idle after second reset", {ready, wr_n}, 3);
    issue(1'b0, 2'd1, 8'h44, 1'b0, "R10 no wake wait after reset");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule